// File: doc/BRIEF.md
# Card-Slot Bank Mapper with Read-Data Bit Reversal

This block sits on a game card and sits between an 8-bit console's card slot and a large external ROM. The slot exposes a 2 MB address space. The lower 1 MB of it is divided into four 256 KB windows. Each window is backed by a writable page register, so that any of 32 pages of 256 KB (8 MB in total) can be placed in it. The upper 1 MB holds two user memory regions, each with its own active-low chip select, and a small register window where software programs the page registers and a bit-reversal flag.

Some consoles wire the card data lines in reverse order. For those consoles software sets the reversal flag after it has identified the console, and from then on ROM read data leaves the block with bit 0 and bit 7 exchanged, bit 1 and bit 6 exchanged, and so on. Register writes are not reversed, and user-memory traffic is not reversed either. Optionally, ROM reads can be held off until the slot reset line has gone high once.

The slot bus has no valid/ready handshake and no back-pressure. The console sets the timing of every access through its strobes. The ROM enables, the chip selects and the read data follow the strobes combinationally. Only the register contents are clocked.

Top module: `card_mapper`

## Requirements
- R1: After power reset every page register holds 0 and the reversal flag is clear. A read of window w at offset 0x1FD0 therefore presents `rom_addr` = 0x1FD0, and ROM data passes through unreversed.
- R2: An access with `slot_addr[20]`=0 selects window w=`slot_addr[19:18]`. `rom_addr` is then {page of window w, `slot_addr[17:0]`}.
- R3: A write with `slot_addr[20:18]`=3'b111 and `slot_addr[2:0]`=w (w<4) loads `slot_wdata[4:0]` into page register w at the next clock edge. Bits 7:5 of the write data are ignored, and the full page range 0 to 31 is accepted.
- R4: A write to the register window with `slot_addr[2:0]`=4 loads `slot_wdata[0]` into the reversal flag. While the flag is 1, a ROM read returns `rom_data` with bit i moved to bit 7-i. While the flag is 0, it returns `rom_data` unchanged.
- R5: Register writes use the slot data exactly as presented, whatever the state of the reversal flag.
- R6: `ucs_n[i]` is low exactly when `slot_ce_n` is low, `slot_addr[20:18]` equals {1, i}, and either strobe is low. During such an access the block does not drive read data.
- R7: `slot_rdata_oe` is high only during an enabled ROM read. At every other time `slot_rdata` is 0.
- R8: When GATE_ON_RESET=1, `rom_ce_n` and `rom_oe_n` stay high until `slot_rst_n` has been seen high since power reset. They open in the same cycle that `slot_rst_n` first goes high and stay open if it falls again. When GATE_ON_RESET=0, ROM reads do not depend on `slot_rst_n`.
- R9: `rom_ce_n` is low for any enabled ROM-region access. `rom_oe_n` is low only when that access is a read. Both stay high during register-window and user-region accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power reset |
| slot_addr | input | 21 | Slot address |
| slot_wdata | input | 8 | Slot write data, raw |
| slot_ce_n | input | 1 | Card enable, active low |
| slot_rd_n | input | 1 | Read strobe, active low |
| slot_wr_n | input | 1 | Write strobe, active low |
| slot_rst_n | input | 1 | Slot reset line |
| slot_rdata | output | 8 | Read data toward the slot |
| slot_rdata_oe | output | 1 | Drive enable for `slot_rdata` |
| rom_addr | output | 23 | ROM address {page, offset} |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_data | input | 8 | ROM read data |
| ucs_n | output | 2 | User chip selects, active low |

## Verification
The hardest case to reach is a register write while reversal is active. A bug that reversed write data would only show up as a wrong page, and only for asymmetric values. The bench therefore sets the flag first and then writes pages whose reversed forms differ, checking the resulting ROM addresses. The second hard case is the sticky reset gate, which needs `slot_rst_n` held low across clock edges, then raised, then dropped again. The bench reaches it by keeping the slot reset low through the first reads after power reset. A second instance built without the gate is driven with the same stimulus for comparison.

// File: rtl/card_mapper_pkg.sv
package card_mapper_pkg;
  typedef enum logic [2:0] {
    RG_ROM,
    RG_UCS0,
    RG_UCS1,
    RG_IDLE,
    RG_REGS
  } region_e;
endpackage

// File: rtl/card_mapper_decode.sv
module card_mapper_decode
  import card_mapper_pkg::*;
#(
  parameter int SLOT_AW = 21,
  parameter int OFS_W   = 18
) (
  input  logic [SLOT_AW-1:0]          addr,
  input  logic                        ce_n,
  input  logic                        rd_n,
  input  logic                        wr_n,
  output region_e                     region,
  output logic [SLOT_AW-OFS_W-2:0]    win,
  output logic                        is_rd,
  output logic                        is_wr
);
  localparam int WIN_W = SLOT_AW - OFS_W - 1;

  assign win   = addr[SLOT_AW-2:OFS_W];
  assign is_rd = ~ce_n & ~rd_n;
  assign is_wr = ~ce_n & ~wr_n;

  always_comb begin
    if (!addr[SLOT_AW-1])                 region = RG_ROM;
    else if (win == WIN_W'(0))            region = RG_UCS0;
    else if (win == WIN_W'(1))            region = RG_UCS1;
    else if (win == {WIN_W{1'b1}})        region = RG_REGS;
    else                                  region = RG_IDLE;
  end
endmodule

// File: rtl/card_mapper_regs.sv
module card_mapper_regs #(
  parameter int NBANK     = 4,
  parameter int PAGE_W    = 5,
  parameter int DATA_W    = 8,
  parameter int REG_SEL_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_SEL_W-1:0]          sel,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          slot_rst_n,
  output logic [NBANK-1:0][PAGE_W-1:0]  pages,
  output logic                          swap,
  output logic                          rel_seen
);
  localparam logic [REG_SEL_W-1:0] SWAP_SEL = REG_SEL_W'(NBANK);

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:PAGE_W];

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              pages[k] <= '0;
      else if (wr_en && sel == REG_SEL_W'(k))  pages[k] <= wdata[PAGE_W-1:0];
    end

    // R3: a bank write lands in the addressed page register one edge later
    p_bank_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == REG_SEL_W'(k)) |=> (pages[k] == $past(wdata[PAGE_W-1:0])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         swap <= 1'b0;
    else if (wr_en && sel == SWAP_SEL)  swap <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rel_seen <= 1'b0;
    else if (slot_rst_n) rel_seen <= 1'b1;
  end

  // R4: flag follows write data bit 0
  p_swap_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SWAP_SEL) |=> (swap == $past(wdata[0])));

  // R8: once released, the gate stays open
  p_release_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_seen |=> rel_seen);
endmodule

// File: rtl/card_mapper_datapath.sv
module card_mapper_datapath #(
  parameter int NBANK  = 4,
  parameter int PAGE_W = 5,
  parameter int OFS_W  = 18,
  parameter int DATA_W = 8,
  parameter int WIN_W  = 2
) (
  input  logic [NBANK-1:0][PAGE_W-1:0]  pages,
  input  logic [WIN_W-1:0]              win,
  input  logic [OFS_W-1:0]              offset,
  input  logic                          swap,
  input  logic [DATA_W-1:0]             rom_data,
  output logic [PAGE_W+OFS_W-1:0]       rom_addr,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] reversed;

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign reversed[b] = rom_data[DATA_W-1-b];
  end

  assign rom_addr = {pages[win], offset};
  assign rdata    = swap ? reversed : rom_data;
endmodule

// File: rtl/card_mapper.sv
module card_mapper
  import card_mapper_pkg::*;
#(
  parameter int SLOT_AW       = 21,
  parameter int OFS_W         = 18,
  parameter int PAGE_W        = 5,
  parameter int DATA_W        = 8,
  parameter bit GATE_ON_RESET = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SLOT_AW-1:0]         slot_addr,
  input  logic [DATA_W-1:0]          slot_wdata,
  input  logic                       slot_ce_n,
  input  logic                       slot_rd_n,
  input  logic                       slot_wr_n,
  input  logic                       slot_rst_n,
  output logic [DATA_W-1:0]          slot_rdata,
  output logic                       slot_rdata_oe,
  output logic [PAGE_W+OFS_W-1:0]    rom_addr,
  output logic                       rom_ce_n,
  output logic                       rom_oe_n,
  input  logic [DATA_W-1:0]          rom_data,
  output logic [1:0]                 ucs_n
);
  localparam int WIN_W     = SLOT_AW - OFS_W - 1;
  localparam int NBANK     = 2 ** WIN_W;
  localparam int REG_SEL_W = $clog2(NBANK + 1);

  region_e                         region;
  logic [WIN_W-1:0]                win;
  logic                            is_rd, is_wr;
  logic [NBANK-1:0][PAGE_W-1:0]    pages;
  logic                            swap, rel_seen, rd_open, rom_act, reg_wr;
  logic [DATA_W-1:0]               rdata_raw;

  card_mapper_decode #(.SLOT_AW(SLOT_AW), .OFS_W(OFS_W)) i_decode (
    .addr(slot_addr), .ce_n(slot_ce_n), .rd_n(slot_rd_n), .wr_n(slot_wr_n),
    .region(region), .win(win), .is_rd(is_rd), .is_wr(is_wr)
  );

  assign reg_wr = (region == RG_REGS) && is_wr;

  card_mapper_regs #(.NBANK(NBANK), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                     .REG_SEL_W(REG_SEL_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr),
    .sel(slot_addr[REG_SEL_W-1:0]), .wdata(slot_wdata),
    .slot_rst_n(slot_rst_n), .pages(pages), .swap(swap), .rel_seen(rel_seen)
  );

  card_mapper_datapath #(.NBANK(NBANK), .PAGE_W(PAGE_W), .OFS_W(OFS_W),
                         .DATA_W(DATA_W), .WIN_W(WIN_W)) i_dp (
    .pages(pages), .win(win), .offset(slot_addr[OFS_W-1:0]), .swap(swap),
    .rom_data(rom_data), .rom_addr(rom_addr), .rdata(rdata_raw)
  );

  assign rd_open       = GATE_ON_RESET ? (rel_seen | slot_rst_n) : 1'b1;
  assign rom_act       = (region == RG_ROM) && (is_rd || is_wr) && rd_open;
  assign rom_ce_n      = ~rom_act;
  assign rom_oe_n      = ~(rom_act && is_rd);
  assign slot_rdata_oe = rom_act && is_rd;
  assign slot_rdata    = slot_rdata_oe ? rdata_raw : '0;
  assign ucs_n[0]      = ~((region == RG_UCS0) && (is_rd || is_wr));
  assign ucs_n[1]      = ~((region == RG_UCS1) && (is_rd || is_wr));

  // R6: at most one device selected at a time
  p_one_device_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ucs_n, ~rom_ce_n}));

  // R7: read data driven only alongside a ROM output enable
  p_drive_rom_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rdata_oe |-> (!rom_oe_n && ucs_n == 2'b11));

  // R8: gate closed before the slot reset has ever been high
  p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (GATE_ON_RESET && !rel_seen && !slot_rst_n) |-> (rom_ce_n && rom_oe_n));

  // R9: no ROM enable during a register write
  p_regwin_norom_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (rom_ce_n && rom_oe_n && !slot_rdata_oe));
endmodule

// File: tb/test_card_mapper.sv
module test_card_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] slot_addr = '0;
  logic [7:0]  slot_wdata = '0;
  logic        slot_ce_n = 1'b1, slot_rd_n = 1'b1, slot_wr_n = 1'b1;
  logic        slot_rst_n = 1'b0;
  logic [7:0]  rom_data = '0;
  logic [7:0]  slot_rdata, slot_rdata_ng;
  logic        slot_rdata_oe, slot_rdata_oe_ng;
  logic [22:0] rom_addr, rom_addr_ng;
  logic        rom_ce_n, rom_oe_n, rom_ce_n_ng, rom_oe_n_ng;
  logic [1:0]  ucs_n, ucs_n_ng;

  int vectors = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  card_mapper i_card_mapper (
    .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr), .slot_wdata(slot_wdata),
    .slot_ce_n(slot_ce_n), .slot_rd_n(slot_rd_n), .slot_wr_n(slot_wr_n),
    .slot_rst_n(slot_rst_n), .slot_rdata(slot_rdata), .slot_rdata_oe(slot_rdata_oe),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_data(rom_data), .ucs_n(ucs_n)
  );

  card_mapper #(.GATE_ON_RESET(1'b0)) i_card_mapper_ng (
    .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr), .slot_wdata(slot_wdata),
    .slot_ce_n(slot_ce_n), .slot_rd_n(slot_rd_n), .slot_wr_n(slot_wr_n),
    .slot_rst_n(slot_rst_n), .slot_rdata(slot_rdata_ng), .slot_rdata_oe(slot_rdata_oe_ng),
    .rom_addr(rom_addr_ng), .rom_ce_n(rom_ce_n_ng), .rom_oe_n(rom_oe_n_ng),
    .rom_data(rom_data), .ucs_n(ucs_n_ng)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r = r | (8'(v[i]) << (7 - i));
    return r;
  endfunction

  function automatic logic [20:0] rom_a(input int w, input int off);
    return {1'b0, 2'(w), 18'(off)};
  endfunction

  function automatic logic [20:0] reg_a(input int sel);
    return {3'b111, 15'd0, 3'(sel)};
  endfunction

  task automatic idle_bus();
    slot_ce_n = 1'b1; slot_rd_n = 1'b1; slot_wr_n = 1'b1;
  endtask

  task automatic reg_write(input int sel, input logic [7:0] d);
    @(negedge clk);
    slot_addr = reg_a(sel); slot_wdata = d;
    slot_ce_n = 1'b0; slot_wr_n = 1'b0; slot_rd_n = 1'b1;
    #1;
    chk(rom_ce_n && rom_oe_n && !slot_rdata_oe, "R9", "rom enable in reg write",
        {rom_ce_n, rom_oe_n, slot_rdata_oe}, 3'b110);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic start_read(input logic [20:0] a);
    @(negedge clk);
    slot_addr = a; slot_ce_n = 1'b0; slot_rd_n = 1'b0; slot_wr_n = 1'b1;
    #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 gate closed while slot reset low, across clock edges
    start_read(rom_a(0, 'h1FD0));
    chk(rom_oe_n && rom_ce_n && !slot_rdata_oe, "R8", "gated rom before release",
        {rom_ce_n, rom_oe_n, slot_rdata_oe}, 3'b110);
    chk(!rom_oe_n_ng && slot_rdata_oe_ng, "R8", "ungated variant reads",
        {rom_oe_n_ng, slot_rdata_oe_ng}, 2'b01);
    chk(rom_addr_ng == 23'h1FD0, "R1", "header address at reset", rom_addr_ng, 23'h1FD0);
    chk(slot_rdata == 8'h00, "R7", "no data while gated", slot_rdata, 0);
    @(negedge clk); #1;
    chk(rom_oe_n, "R8", "still gated after edge", rom_oe_n, 1);
    @(negedge clk);
    slot_rst_n = 1'b1; #1;
    chk(!rom_oe_n && !rom_ce_n, "R8", "opens with slot reset high",
        {rom_ce_n, rom_oe_n}, 2'b00);
    @(negedge clk);
    slot_rst_n = 1'b0; #1;
    chk(!rom_oe_n, "R8", "stays open after slot reset falls", rom_oe_n, 0);
    idle_bus();

    // R1 power-on pages and no reversal
    for (int w = 0; w < 4; w++) begin
      rom_data = 8'h01;
      start_read(rom_a(w, 'h1FD0));
      chk(rom_addr == 23'h1FD0, "R1", "page 0 in every window", rom_addr, 23'h1FD0);
      chk(slot_rdata == 8'h01, "R1", "no reversal at reset", slot_rdata, 8'h01);
      idle_bus();
    end

    // R2 R3 page sweep with junk upper bits
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 32; p++) begin
        int off;
        off = (p * 8191 + w * 977) % 262144;
        reg_write(w, {3'(p + w + 5), 5'(p)});
        start_read(rom_a(w, off));
        chk(rom_addr == 23'((p << 18) + off), "R3", "page load and address",
            rom_addr, (p << 18) + off);
        chk(!rom_ce_n && !rom_oe_n, "R9", "rom enabled on read",
            {rom_ce_n, rom_oe_n}, 2'b00);
        idle_bus();
      end
    end
    // R2 distinct pages per window
    for (int w = 0; w < 4; w++) reg_write(w, 8'(3 * w + 1));
    for (int w = 0; w < 4; w++) begin
      start_read(rom_a(w, 'h2A5A5));
      chk(rom_addr == 23'(((3 * w + 1) << 18) + 'h2A5A5), "R2", "window to page",
          rom_addr, ((3 * w + 1) << 18) + 'h2A5A5);
      idle_bus();
    end
    // R9 ROM-region write enables chip but not output
    @(negedge clk);
    slot_addr = rom_a(1, 5); slot_ce_n = 1'b0; slot_wr_n = 1'b0; #1;
    chk(!rom_ce_n && rom_oe_n && !slot_rdata_oe, "R9", "rom write strobes",
        {rom_ce_n, rom_oe_n, slot_rdata_oe}, 3'b010);
    idle_bus();

    // R4 data sweep without and with reversal
    for (int s = 0; s < 2; s++) begin
      reg_write(4, {7'h55, 1'(s)});
      for (int d = 0; d < 256; d++) begin
        rom_data = 8'(d);
        start_read(rom_a(d % 4, d));
        chk(slot_rdata == (s != 0 ? rev8(8'(d)) : 8'(d)), "R4", "read data ordering",
            slot_rdata, (s != 0 ? rev8(8'(d)) : 8'(d)));
        idle_bus();
      end
    end

    // R5 writes raw while reversal on (flag is 1 here)
    for (int p = 1; p < 32; p = p * 2 + 1) begin
      reg_write(2, 8'(p));
      start_read(rom_a(2, 0));
      chk(rom_addr == 23'(p << 18), "R5", "raw write data with reversal on",
          rom_addr, p << 18);
      idle_bus();
    end

    // R6 user regions: rd, wr, none; and card disabled
    for (int i = 0; i < 2; i++) begin
      for (int m = 0; m < 3; m++) begin
        logic [1:0] exp_u;
        @(negedge clk);
        slot_addr = {1'b1, 2'(i), 18'h00123};
        slot_ce_n = 1'b0; slot_rd_n = (m != 0); slot_wr_n = (m != 1); #1;
        exp_u = (m == 2) ? 2'b11 : ~(2'b01 << i);
        chk(ucs_n == exp_u, "R6", "user chip select", ucs_n, exp_u);
        chk(!slot_rdata_oe && rom_ce_n && slot_rdata == 8'h00, "R7", "no drive in user region",
            {slot_rdata_oe, rom_ce_n}, 2'b01);
        idle_bus();
      end
      @(negedge clk);
      slot_addr = {1'b1, 2'(i), 18'h0}; slot_rd_n = 1'b0; #1;
      chk(ucs_n == 2'b11, "R6", "no select without card enable", ucs_n, 2'b11);
      idle_bus();
    end
    // R7 idle window and register read
    start_read({3'b110, 18'h0});
    chk(!slot_rdata_oe && ucs_n == 2'b11 && rom_ce_n, "R7", "idle window silent",
        {slot_rdata_oe, ucs_n, rom_ce_n}, 4'b0111);
    idle_bus();
    start_read(reg_a(0));
    chk(!slot_rdata_oe && rom_oe_n, "R9", "register read no rom",
        {slot_rdata_oe, rom_oe_n}, 2'b01);
    idle_bus();

    // R1 power reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; slot_rst_n = 1'b1;
    rom_data = 8'h03;
    start_read(rom_a(3, 'h1FD0));
    chk(rom_addr == 23'h1FD0 && slot_rdata == 8'h03, "R1", "defaults after reset",
        {rom_addr, slot_rdata}, {23'h1FD0, 8'h03});
    idle_bus();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule